// File: doc/BRIEF.md
# One-Hot Diagonal Right Shifter

This block shifts an N-bit word toward its least significant end by a distance from 0 to N-1 in a single combinational pass. It is modelled as a square crossbar of switches. Each of the N select lines turns on one diagonal of that crossbar, and the diagonal for distance k connects input bit a[i+k] to output bit b[i]. An output bit with no connected input reads as zero, so the shift is logical. N defaults to 4.

The distance arrives as a one-hot select vector, not as a binary count. A select with no line set, or with several lines set, is illegal. In that case the block drives an all-zero result and raises an error flag, so that two diagonals are never enabled at once. There is no clock and no storage: the outputs follow the inputs within the same time step.

Top module: `diag_shifter`

## Requirements
- R1: With sel equal to 1 (bit 0 alone set, distance zero), b equals a on every bit.
- R2: With only sel bit k set, b equals a logically shifted right by k positions. Bit k of sel selects distance k.
- R3: Under a legal select with distance k, the k most significant bits of b are 0.
- R4: With only sel bit 1 set, a[1] appears on b[0], a[2] on b[1] and a[3] on b[2], and b[3] is 0.
- R5: When sel is all zero, b is all zero and err is 1.
- R6: When two or more bits of sel are set, b is all zero and err is 1, whatever the value of a.
- R7: When exactly one bit of sel is set, err is 0.
- R8: The block holds no state. A change on a or sel shows on b and err without any clock edge, and an earlier input leaves no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Data word to be shifted |
| sel | input | N | One-hot distance select; bit k picks distance k |
| b | output | N | Shifted word; zero on an illegal select |
| err | output | 1 | High when sel is not one-hot |

## Verification
The case that is hardest to reach from the ports is a select with several lines raised. Under that select, two diagonals would fight over the same output bit if the block did not gate the enables. The bench makes this case certain rather than incidental: it drives all 2^N select patterns against every data word. Each of the eleven multi-bit patterns is therefore paired with data words whose set bits lie under more than one active diagonal, and for each of them the result must still come back as zero.

// File: rtl/diag_shifter_pkg.sv
package diag_shifter_pkg;

  typedef enum logic [1:0] {
    SEL_OK    = 2'd0,
    SEL_NONE  = 2'd1,
    SEL_MULTI = 2'd2
  } sel_status_e;

endpackage

// File: rtl/diag_sel_check.sv
module diag_sel_check
  import diag_shifter_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] sel,
  output sel_status_e  status,
  output logic [N-1:0] en
);

  logic [N:0]   seen;
  logic [N-1:0] dup;

  assign seen[0] = 1'b0;

  generate
    for (genvar k = 0; k < N; k++) begin : g_scan
      assign seen[k+1] = seen[k] | sel[k];
      assign dup[k]    = sel[k] & seen[k];
    end
  endgenerate

  always_comb begin
    if (!seen[N])     status = SEL_NONE;
    else if (|dup)    status = SEL_MULTI;
    else              status = SEL_OK;
  end

  assign en = (status == SEL_OK) ? sel : '0;

  always_comb begin
    if (status == SEL_NONE) begin
      AST_NONE_IS_EMPTY: assert (sel == '0);                 // R5
    end
    if (status == SEL_MULTI) begin
      AST_MULTI_IS_PLURAL: assert ($countones(sel) > 1);     // R6
    end
  end

endmodule

// File: rtl/diag_xbar.sv
module diag_xbar #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] en,
  output logic [N-1:0] b
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_out
      logic [N-1:0] tap;
      for (genvar k = 0; k < N; k++) begin : g_diag
        if (i + k < N) begin : g_sw
          assign tap[k] = en[k] & a[i+k];
        end else begin : g_open
          assign tap[k] = 1'b0;
        end
      end
      assign b[i] = |tap;
    end
  endgenerate

  always_comb begin
    AST_ONE_DIAGONAL: assert ($onehot0(en));                 // R6
    if (en != '0 && !en[0]) begin
      AST_TOP_VACATED: assert (b[N-1] == 1'b0);              // R3
    end
  end

endmodule

// File: rtl/diag_shifter.sv
module diag_shifter
  import diag_shifter_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] sel,
  output logic [N-1:0] b,
  output logic         err
);

  sel_status_e  status;
  logic [N-1:0] en;

  diag_sel_check #(.N(N)) u_check (
    .sel    (sel),
    .status (status),
    .en     (en)
  );

  diag_xbar #(.N(N)) u_xbar (
    .a  (a),
    .en (en),
    .b  (b)
  );

  assign err = (status != SEL_OK);

  always_comb begin
    if (err) begin
      AST_ERR_ZERO_OUT: assert (b == '0);                    // R5
    end
    if (sel == N'(1)) begin
      AST_PASS_THROUGH: assert (b == a);                     // R1
    end
    if ($onehot(sel)) begin
      AST_LEGAL_NO_ERR: assert (!err);                       // R7
    end
  end

endmodule

// File: tb/diag_shifter_tb.sv
module diag_shifter_tb_top;

  localparam int N = 4;
  localparam int NVEC = 9;

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] sel;
    logic [3:0] b;
    logic       err;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'b1011, 4'b0001, 4'b1011, 1'b0},
    '{4'b1011, 4'b0010, 4'b0101, 1'b0},
    '{4'b1011, 4'b0100, 4'b0010, 1'b0},
    '{4'b1011, 4'b1000, 4'b0001, 1'b0},
    '{4'b1111, 4'b1000, 4'b0001, 1'b0},
    '{4'b0110, 4'b0100, 4'b0001, 1'b0},
    '{4'b1001, 4'b0010, 4'b0100, 1'b0},
    '{4'b1111, 4'b0000, 4'b0000, 1'b1},
    '{4'b1111, 4'b0110, 4'b0000, 1'b1}
  };

  logic         clk;
  logic [N-1:0] a, sel, b;
  logic         err;
  int           n_chk, n_bad, cyc;
  bit           done;

  diag_shifter #(.N(N)) dut_i (.a(a), .sel(sel), .b(b), .err(err));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] exp_b,
                       input logic exp_e);
    n_chk++;
    if (b !== exp_b || err !== exp_e) begin
      n_bad++;
      $display("FAIL %s: a=%b sel=%b got b=%b err=%b, want b=%b err=%b",
               req, a, sel, b, err, exp_b, exp_e);
    end
  endtask

  task automatic apply(input logic [N-1:0] av, input logic [N-1:0] sv);
    @(posedge clk);
    a = av; sel = sv;
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    a = '0; sel = '0;
    @(negedge clk);
    check("R5 initial", '0, 1'b1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v].a, VECS[v].sel);
      check(VECS[v].err ? "R5/R6 table" : "R2 table", VECS[v].b, VECS[v].err);
    end

    // exhaustive: every data word against every select pattern
    for (int av = 0; av < (1 << N); av++) begin
      for (int sv = 0; sv < (1 << N); sv++) begin
        int ones, k;
        logic [N-1:0] eb;
        ones = 0; k = 0;
        for (int j = 0; j < N; j++) if (sv[j]) begin ones++; k = j; end
        apply(N'(av), N'(sv));
        if (ones == 1) begin
          eb = N'(av) >> k;
          if (k == 0) check("R1", eb, 1'b0);
          else if (k == 1) check("R4", eb, 1'b0);
          else check("R2/R3/R7", eb, 1'b0);
        end else if (ones == 0) begin
          check("R5", '0, 1'b1);
        end else begin
          check("R6", '0, 1'b1);
        end
      end
    end

    // R3: all-ones data shows the vacated top bits directly
    apply('1, 4'b0100);
    check("R3 top two bits clear", 4'b0011, 1'b0);

    // R8: change inputs with no clock edge and look within the same step
    @(negedge clk);
    a = 4'b1100; sel = 4'b0100;
    #1;
    check("R8 no clock needed", 4'b0011, 1'b0);
    sel = 4'b0001;
    #1;
    check("R8 no memory of prior input", 4'b1100, 1'b0);
    a = 4'b0000;
    #1;
    check("R8 follows data", 4'b0000, 1'b0);

    done = 1;
  end

  initial begin
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, got %0d cycles, want fewer", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule